// File: doc/BRIEF.md
# Filter Coefficient Loader with Readback

This block collects the tap weights for a polyphase scaling filter. A host presents 32-bit words that each carry two signed 16-bit coefficients, raising a write strobe for each word. The loader accepts a word only after the strobe has stayed high for a few clocks, so a strobe that comes from a slow or glitchy source is tolerated. Accepted words fill a coefficient set in a fixed sequence. The sequence steps through tap pairs, then phases, then the four banks of a set. The banks come in the order vertical luma, vertical chroma, horizontal luma, horizontal chroma.

Once a whole set has been written the loader drops its ready flag and gives a one-cycle completion pulse. It refuses further words until vertical blanking re-arms it. Any stored coefficient can be read back at any time, including while a load is in progress. The read port selects a set, a bank code and a flat address, and the value appears a fixed three clocks later.

Top module: `coef_loader`

## Requirements
- R1: After reset, coef_rdy is 1, set_done is 0, coef_mem_output is 0 and every stored coefficient reads back as 0.
- R2: A word is stored on the third consecutive rising edge at which coef_wr_en is sampled high; a strobe high for fewer than three edges stores nothing.
- R3: At most one word is stored per high period of coef_wr_en, however long the strobe stays high.
- R4: Accepted word j of a phase stores bits 15:0 as tap 2j and bits 31:16 as tap 2j+1. Words advance through ceil(TAPS/2) tap pairs, then through PHASES phases, then through banks in the order VY, VC, HY, HC. They go into the set given by coef_wr_set when the word is taken.
- R5: With an odd tap count, the upper half of the last word of each phase is discarded and changes no stored coefficient.
- R6: Readback bank codes are 00 horizontal luma, 01 horizontal chroma, 10 vertical luma and 11 vertical chroma. rd_addr is phase*TAPS + tap, and rd_set selects the set.
- R7: coef_mem_output shows the coefficient addressed by rd_set, rd_bank and rd_addr three clock edges after those inputs are applied, and holds the previous result until then.
- R8: The edge that stores the final word of the horizontal chroma bank drives coef_rdy low and set_done high for exactly one cycle. coef_rdy falls at no other time.
- R9: While coef_rdy is 0, strobed words are ignored and no stored coefficient changes.
- R10: vblank_in sampled high while coef_rdy is 0 sets coef_rdy to 1 at that edge, and the next load starts again at VY, phase 0, tap pair 0.
- R11: A readback with rd_addr of PHASES*TAPS or more returns 0.
- R12: Readback running concurrently with a load disturbs neither the stored values nor the write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_data_in | input | 32 | Two packed signed coefficients |
| coef_wr_en | input | 1 | Write strobe, qualified by stability |
| coef_wr_set | input | 1 | Set receiving the words |
| vblank_in | input | 1 | Vertical blanking, re-arms loading |
| rd_set | input | 1 | Readback set select |
| rd_bank | input | 2 | Readback bank code |
| rd_addr | input | 5 | Readback flat address phase*TAPS+tap |
| coef_rdy | output | 1 | High while words are being accepted |
| set_done | output | 1 | One-cycle pulse when a set is complete |
| coef_mem_output | output | 16 | Readback coefficient |

## Verification
The hardest condition to reach is the end of a phase with an odd tap count. At that point a nonzero padding half must not spill into tap 0 of the next phase, and the only way to see it is a complete, correctly sequenced load followed by a read of every address. The stimulus loads two full sets with nonzero upper halves in every padding position. It mixes in a short strobe, an over-long strobe and a word sent while the loader is closed, then sweeps every bank code and address of both sets. A reader keeps changing the readback address on every cycle during the loads, so that concurrent readback is exercised against a behavioural model compared on each clock.

// File: rtl/coef_ld_pkg.sv
`timescale 1ns/1ps
package coef_ld_pkg;
   // bank slots in storage follow the write sequence
   typedef enum logic [1:0] {
      BK_VY = 2'd0,
      BK_VC = 2'd1,
      BK_HY = 2'd2,
      BK_HC = 2'd3
   } bank_e;

   localparam int NUM_BANKS = 4;

   // readback code: 00 HY, 01 HC, 10 VY, 11 VC -> storage slot
   function automatic logic [1:0] slot_of_code(input logic [1:0] code);
      return {~code[1], code[0]};
   endfunction
endpackage

// File: rtl/coef_strobe_qual.sv
`timescale 1ns/1ps
module coef_strobe_qual #(
   parameter int STABLE = 3,
   localparam int CNT_W = $clog2(STABLE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic accept
);
   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!strobe) begin
         run_q <= '0;
      end else if (run_q != CNT_W'(STABLE)) begin
         run_q <= run_q + 1'b1;
      end
   end

   // fires on the STABLE-th consecutive high sample, once per high period
   assign accept = strobe && (run_q == CNT_W'(STABLE - 1));
endmodule

// File: rtl/coef_wr_seq.sv
`timescale 1ns/1ps
module coef_wr_seq import coef_ld_pkg::*; #(
   parameter int TAPS   = 5,
   parameter int PHASES = 4,
   localparam int WPP    = (TAPS + 1) / 2,
   localparam int PAIR_W = (WPP > 1) ? $clog2(WPP) : 1,
   localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              vblank,
   output logic              we,
   output logic [1:0]        bank,
   output logic [PH_W-1:0]   phase,
   output logic [PAIR_W-1:0] pair,
   output logic              rdy,
   output logic              done
);
   localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(WPP - 1);
   localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(PHASES - 1);

   assign we = accept && rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pair  <= '0;
         phase <= '0;
         bank  <= BK_VY;
         rdy   <= 1'b1;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (we) begin
            if (pair == LAST_PAIR) begin
               pair <= '0;
               if (phase == LAST_PH) begin
                  phase <= '0;
                  if (bank == BK_HC) begin
                     bank <= BK_VY;
                     rdy  <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bank <= bank + 2'd1;
                  end
               end else begin
                  phase <= phase + 1'b1;
               end
            end else begin
               pair <= pair + 1'b1;
            end
         end else if (vblank && !rdy) begin
            rdy <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/coef_store.sv
`timescale 1ns/1ps
module coef_store import coef_ld_pkg::*; #(
   parameter int COEF_W = 16,
   parameter int SETS   = 2,
   parameter int TAPS   = 5,
   parameter int PHASES = 4,
   localparam int DATA_W  = 2 * COEF_W,
   localparam int WPP     = (TAPS + 1) / 2,
   localparam int PAIR_W  = (WPP > 1) ? $clog2(WPP) : 1,
   localparam int PH_W    = (PHASES > 1) ? $clog2(PHASES) : 1,
   localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int ENTRIES = PHASES * TAPS,
   localparam int RA_W    = $clog2(ENTRIES),
   localparam int DEPTH   = SETS * NUM_BANKS * ENTRIES,
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SET_W-1:0]  wset,
   input  logic [1:0]        wbank,
   input  logic [PH_W-1:0]   wphase,
   input  logic [PAIR_W-1:0] wpair,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SET_W-1:0]  rset,
   input  logic [1:0]        rcode,
   input  logic [RA_W-1:0]   raddr,
   output logic [COEF_W-1:0] rdata
);
   logic [COEF_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  lo_idx, hi_idx, rd_idx;
   logic              hi_ok, wset_ok, rd_ok;

   logic [SET_W-1:0]  rs_q;
   logic [1:0]        rb_q;
   logic [RA_W-1:0]   ra_q;
   logic [COEF_W-1:0] d2_q;

   always_comb begin
      int base;
      int rbase;
      base    = ((int'(wset) * NUM_BANKS + int'(wbank)) * PHASES + int'(wphase)) * TAPS
                + 2 * int'(wpair);
      lo_idx  = IDX_W'(base);
      hi_idx  = IDX_W'(base + 1);
      wset_ok = (int'(wset) < SETS);
      rbase   = (int'(rs_q) * NUM_BANKS + int'(rb_q)) * ENTRIES + int'(ra_q);
      rd_idx  = IDX_W'(rbase);
      rd_ok   = (int'(ra_q) < ENTRIES) && (int'(rs_q) < SETS);
   end

   // padding half exists only for odd tap counts
   if (TAPS % 2 == 1) begin : g_odd_taps
      assign hi_ok = (wpair != PAIR_W'(WPP - 1));
   end else begin : g_even_taps
      assign hi_ok = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && wset_ok) begin
         mem[lo_idx] <= wdata[COEF_W-1:0];
         if (hi_ok) mem[hi_idx] <= wdata[DATA_W-1:COEF_W];
      end
   end

   // three registers from address to output
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_q  <= '0;
         rb_q  <= '0;
         ra_q  <= '0;
         d2_q  <= '0;
         rdata <= '0;
      end else begin
         rs_q  <= rset;
         rb_q  <= slot_of_code(rcode);
         ra_q  <= raddr;
         d2_q  <= rd_ok ? mem[rd_idx] : '0;
         rdata <= d2_q;
      end
   end
endmodule

// File: rtl/coef_loader.sv
`timescale 1ns/1ps
module coef_loader import coef_ld_pkg::*; #(
   parameter int COEF_W = 16,
   parameter int SETS   = 2,
   parameter int TAPS   = 5,
   parameter int PHASES = 4,
   parameter int STABLE = 3,
   localparam int DATA_W  = 2 * COEF_W,
   localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int ENTRIES = PHASES * TAPS,
   localparam int RA_W    = $clog2(ENTRIES),
   localparam int WPP     = (TAPS + 1) / 2,
   localparam int PAIR_W  = (WPP > 1) ? $clog2(WPP) : 1,
   localparam int PH_W    = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] coef_data_in,
   input  logic              coef_wr_en,
   input  logic [SET_W-1:0]  coef_wr_set,
   input  logic              vblank_in,
   input  logic [SET_W-1:0]  rd_set,
   input  logic [1:0]        rd_bank,
   input  logic [RA_W-1:0]   rd_addr,
   output logic              coef_rdy,
   output logic              set_done,
   output logic [COEF_W-1:0] coef_mem_output
);
   if (TAPS < 2) begin : g_bad_taps
      $error("coef_loader: TAPS must be at least 2");
   end
   if (STABLE < 2) begin : g_bad_stable
      $error("coef_loader: STABLE must be at least 2");
   end
   if (SETS < 1 || PHASES < 1) begin : g_bad_dims
      $error("coef_loader: SETS and PHASES must be positive");
   end

   logic              acc_w, we_w;
   logic [1:0]        bank_w;
   logic [PH_W-1:0]   phase_w;
   logic [PAIR_W-1:0] pair_w;

   coef_strobe_qual #(.STABLE(STABLE)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (coef_wr_en),
      .accept (acc_w)
   );

   coef_wr_seq #(.TAPS(TAPS), .PHASES(PHASES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (acc_w),
      .vblank (vblank_in),
      .we     (we_w),
      .bank   (bank_w),
      .phase  (phase_w),
      .pair   (pair_w),
      .rdy    (coef_rdy),
      .done   (set_done)
   );

   coef_store #(.COEF_W(COEF_W), .SETS(SETS), .TAPS(TAPS), .PHASES(PHASES)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we_w),
      .wset   (coef_wr_set),
      .wbank  (bank_w),
      .wphase (phase_w),
      .wpair  (pair_w),
      .wdata  (coef_data_in),
      .rset   (rd_set),
      .rcode  (rd_bank),
      .raddr  (rd_addr),
      .rdata  (coef_mem_output)
   );
endmodule

// File: rtl/coef_loader_chk.sv
`timescale 1ns/1ps
module coef_loader_chk #(
   parameter int STABLE  = 3,
   parameter int ENTRIES = 20,
   parameter int RA_W    = 5,
   parameter int COEF_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coef_wr_en,
   input logic              accept,
   input logic              vblank_in,
   input logic              coef_rdy,
   input logic              set_done,
   input logic [RA_W-1:0]   rd_addr,
   input logic [COEF_W-1:0] coef_mem_output
);
   localparam int RUN_W = $clog2(STABLE + 1) + 1;
   logic [RUN_W-1:0] run_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         seen_q <= 1'b0;
      end else if (!coef_wr_en) begin
         run_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (run_q < RUN_W'(STABLE)) run_q <= run_q + 1'b1;
         if (accept) seen_q <= 1'b1;
      end
   end

   p_accept_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (coef_wr_en && run_q == RUN_W'(STABLE - 1)));

   p_one_per_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !seen_q);

   p_done_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |-> !coef_rdy);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |=> !set_done);

   p_fall_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(coef_rdy) |-> set_done);

   p_rearm_vblank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coef_rdy) |-> $past(vblank_in));

   p_oor_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (int'($past(rd_addr, 3)) >= ENTRIES) |-> (coef_mem_output == '0));
endmodule

bind coef_loader coef_loader_chk #(
   .STABLE(STABLE), .ENTRIES(ENTRIES), .RA_W(RA_W), .COEF_W(COEF_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .coef_wr_en      (coef_wr_en),
   .accept          (acc_w),
   .vblank_in       (vblank_in),
   .coef_rdy        (coef_rdy),
   .set_done        (set_done),
   .rd_addr         (rd_addr),
   .coef_mem_output (coef_mem_output)
);

// File: tb/coef_loader_tb_top.sv
`timescale 1ns/1ps
module coef_loader_tb_top;
   localparam int SETS = 2, TAPS = 5, PHASES = 4, WPP = 3;
   localparam int ENTRIES = PHASES * TAPS;
   localparam int WORDS = 4 * PHASES * WPP;
   localparam int DEPTH = SETS * 4 * ENTRIES;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] coef_data_in = '0;
   logic        coef_wr_en = 1'b0;
   logic        coef_wr_set = 1'b0;
   logic        vblank_in = 1'b0;
   logic        rd_set = 1'b0;
   logic [1:0]  rd_bank = '0;
   logic [4:0]  rd_addr = '0;
   logic        coef_rdy, set_done;
   logic [15:0] coef_mem_output;

   int n_cmp = 0, n_bad = 0, done_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   coef_loader dut_i (
      .clk(clk), .rst_n(rst_n), .coef_data_in(coef_data_in), .coef_wr_en(coef_wr_en),
      .coef_wr_set(coef_wr_set), .vblank_in(vblank_in), .rd_set(rd_set),
      .rd_bank(rd_bank), .rd_addr(rd_addr), .coef_rdy(coef_rdy),
      .set_done(set_done), .coef_mem_output(coef_mem_output)
   );

   // ---------------- stimulus data and expectations ----------------
   function automatic logic [15:0] lo_of(int s, int k);
      return 16'(s * 4099 + k * 613 - 9000);
   endfunction
   function automatic logic [15:0] hi_of(int s, int k);
      return 16'(32'h5A5A + s * 777 - k * 1201);
   endfunction
   function automatic int slot_of(int code);
      case (code)
         0: return 2;   // HY
         1: return 3;   // HC
         2: return 0;   // VY
         default: return 1; // VC
      endcase
   endfunction
   function automatic logic [15:0] exp_coef(int s, int code, int addr);
      int ph, tap, k;
      if (addr >= ENTRIES) return 16'h0;
      ph  = addr / TAPS;
      tap = addr % TAPS;
      k   = (slot_of(code) * PHASES + ph) * WPP + tap / 2;
      return (tap % 2 == 1) ? hi_of(s, k) : lo_of(s, k);
   endfunction

   // ---------------- behavioural reference model ----------------
   logic [15:0] mm [DEPTH];
   int m_run, m_word;
   bit m_rdy, m_done;
   int a_set, a_code, a_addr;
   logic [15:0] m_d2, m_out;

   function automatic logic [15:0] m_look(int s, int code, int addr);
      if (addr >= ENTRIES || s >= SETS) return 16'h0;
      return mm[(s * 4 + slot_of(code)) * ENTRIES + addr];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mm[i] = '0;
         m_run = 0; m_word = 0; m_rdy = 1; m_done = 0;
         a_set = 0; a_code = 0; a_addr = 0; m_d2 = '0; m_out = '0;
      end else begin
         bit acc;
         m_out  = m_d2;
         m_d2   = m_look(a_set, a_code, a_addr);
         a_set  = int'(rd_set); a_code = int'(rd_bank); a_addr = int'(rd_addr);
         acc    = coef_wr_en && (m_run == 2);
         if (!coef_wr_en) m_run = 0; else if (m_run < 3) m_run++;
         m_done = 0;
         if (acc && m_rdy) begin
            int bank, ph, pr, base;
            pr   = m_word % WPP;
            ph   = (m_word / WPP) % PHASES;
            bank = m_word / (WPP * PHASES);
            base = (int'(coef_wr_set) * 4 + bank) * ENTRIES + ph * TAPS + 2 * pr;
            mm[base] = coef_data_in[15:0];
            if (2 * pr + 1 < TAPS) mm[base + 1] = coef_data_in[31:16];
            m_word++;
            if (m_word == WORDS) begin m_word = 0; m_rdy = 0; m_done = 1; end
         end else if (vblank_in && !m_rdy) begin
            m_rdy = 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(coef_rdy === m_rdy, "R8 R10 coef_rdy vs model", 32'(coef_rdy), 32'(m_rdy));
         check(set_done === m_done, "R8 set_done vs model", 32'(set_done), 32'(m_done));
         check(coef_mem_output === m_out, "R7 R12 readback vs model",
               32'(coef_mem_output), 32'(m_out));
         if (set_done) done_cnt++;
      end
   end

   // ---------------- tasks ----------------
   task automatic write_word(input logic [31:0] d, input logic s, input int hold);
      @(negedge clk);
      coef_data_in = d; coef_wr_set = s; coef_wr_en = 1'b1;
      repeat (hold) @(negedge clk);
      coef_wr_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic load_set(input int s, input int first_hold);
      for (int k = 0; k < WORDS; k++)
         write_word({hi_of(s, k), lo_of(s, k)}, 1'(s), (k == 0) ? first_hold : 6);
   endtask

   task automatic rd_check(input int s, input int code, input int addr,
                           input logic [15:0] exp, input string tag);
      @(negedge clk);
      rd_set = 1'(s); rd_bank = 2'(code); rd_addr = 5'(addr);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(coef_mem_output === exp, tag, 32'(coef_mem_output), 32'(exp));
   endtask

   // ---------------- main sequence ----------------
   initial begin
      bit busy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(coef_rdy === 1'b1, "R1 ready after reset", 32'(coef_rdy), 32'd1);
      check(set_done === 1'b0, "R1 done low after reset", 32'(set_done), 32'd0);
      check(coef_mem_output === 16'h0, "R1 output zero", 32'(coef_mem_output), 32'd0);
      rd_check(1, 3, 7, 16'h0, "R1 storage zero after reset");

      // two-cycle strobe must store nothing
      write_word(32'h1234_ABCD, 1'b0, 2);
      rd_check(0, 2, 0, 16'h0, "R2 short strobe ignored tap0");
      rd_check(0, 2, 1, 16'h0, "R2 short strobe ignored tap1");

      // load set 0 with a long first strobe while readback sweeps
      busy = 1;
      fork
         begin load_set(0, 12); busy = 0; end
         begin
            while (busy) begin
               @(negedge clk);
               rd_addr = rd_addr + 5'd1;
               if (rd_addr == 5'd0) rd_bank = rd_bank + 2'd1;
            end
         end
      join
      @(negedge clk);
      check(coef_rdy === 1'b0, "R8 ready low after full set", 32'(coef_rdy), 32'd0);
      check(done_cnt == 1, "R8 one completion pulse", 32'(done_cnt), 32'd1);

      // closed loader ignores a word aimed at set 1
      write_word(32'h7777_7777, 1'b1, 6);
      check(coef_rdy === 1'b0, "R9 still closed", 32'(coef_rdy), 32'd0);
      rd_check(1, 2, 0, 16'h0, "R9 ignored word tap0");
      rd_check(1, 2, 1, 16'h0, "R9 ignored word tap1");

      // re-arm with vertical blanking
      @(negedge clk); vblank_in = 1'b1;
      @(negedge clk); vblank_in = 1'b0;
      check(coef_rdy === 1'b1, "R10 ready after vblank", 32'(coef_rdy), 32'd1);
      load_set(1, 6);
      check(done_cnt == 2, "R10 second set completes from VY start", 32'(done_cnt), 32'd2);

      // full sweep of both sets, every bank code and address
      for (int s = 0; s < SETS; s++)
         for (int c = 0; c < 4; c++)
            for (int a = 0; a < ENTRIES; a++)
               rd_check(s, c, a, exp_coef(s, c, a), "R4 R5 R6 R3 stored coefficient");

      // padding half of phase 0 must not reach phase 1 tap 0
      rd_check(0, 2, TAPS, lo_of(0, WPP), "R5 padding discarded");

      // latency: old value for two edges, new value on the third
      rd_check(0, 0, 3, exp_coef(0, 0, 3), "R7 latency setup");
      @(negedge clk); rd_addr = 5'd4;
      @(negedge clk);
      check(coef_mem_output === exp_coef(0, 0, 3), "R7 old value after one edge",
            32'(coef_mem_output), 32'(exp_coef(0, 0, 3)));
      @(negedge clk);
      check(coef_mem_output === exp_coef(0, 0, 3), "R7 old value after two edges",
            32'(coef_mem_output), 32'(exp_coef(0, 0, 3)));
      @(negedge clk);
      check(coef_mem_output === exp_coef(0, 0, 4), "R7 new value after three edges",
            32'(coef_mem_output), 32'(exp_coef(0, 0, 4)));

      rd_check(0, 1, 25, 16'h0, "R11 out-of-range address");
      rd_check(1, 0, ENTRIES, 16'h0, "R11 first out-of-range address");
      check(done_cnt == 2, "R12 no stray completion", 32'(done_cnt), 32'd2);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL R12 watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule